// File: doc/BRIEF.md
# SD Host Vendor Register Front-End

This block decodes a 4 KiB window of 32-bit registers that sits in front of a standard SD host slot register set. The lower part of the window holds a small file of vendor host registers. Three of them have their own rules: a read-only information word that carries a software-reset trigger, a PHY access port that acknowledges on its own, and an eMMC control word whose tuning request clears itself. Every other implemented vendor word is plain storage.

Accesses from byte offset 0x200 upward go to a downstream slot register port with their data unchanged. Their address is rebased so that 0x200 becomes offset 0. The host bus waits on that port's acknowledge. A software reset returns the vendor file to its power-on state and sends the downstream port a reset pulse one cycle long. Only word-aligned accesses are served. Any other access completes at once with an error flag.

The bus uses a request/ready handshake. The requester holds `bus_req` and the access fields steady until it sees `bus_ready` high at a rising clock edge. The access takes effect at that edge.

Top module: `sdvf_frontend`

## Requirements
- R1: After hardware reset, offset 0x00 reads 0x00010000 and every other vendor offset reads 0.
- R2: Offset 0x00 is read-only. A write leaves its read value at 0x00010000, and bit 0 always reads 0.
- R3: A write to offset 0x00 with bit 0 set returns every vendor register to its power-on value at that clock edge.
- R4: That same write drives `slot_rst` high for exactly the one cycle after the accepting edge. No other access drives it.
- R5: At offset 0x10, bit 26 is stored as the OR of written bits 24 and 25. All other bits are stored as written.
- R6: At offset 0x18, bit 15 is always stored as 0 and always reads 0. All other bits are stored as written.
- R7: Every other implemented vendor offset (0x04 to 0x1C by default) stores all 32 bits. Any vendor-range access gets `bus_ready` in the same cycle as its request.
- R8: Vendor offsets from the end of the implemented file up to 0x1FC read 0, and writes to them change nothing.
- R9: Aligned accesses at 0x200 and above raise `slot_req` with `slot_we`, the data, and `slot_addr` equal to address minus 0x200. `bus_ready` follows `slot_ack`, and the read data is `slot_rdata` unchanged.
- R10: An access with address bits [1:0] not zero gets `bus_ready` and `bus_err` at once, returns 0, changes no register, and is never forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request, held until ready |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes at this edge |
| bus_err | output | 1 | Misaligned access flag, valid with ready |
| bus_rdata | output | 32 | Read data, valid with ready |
| slot_req | output | 1 | Forwarded request to the slot port |
| slot_we | output | 1 | Forwarded write enable |
| slot_addr | output | ADDR_W | Byte offset from the slot base |
| slot_wdata | output | 32 | Forwarded write data |
| slot_ack | input | 1 | Slot port completion |
| slot_rdata | input | 32 | Slot port read data |
| slot_rst | output | 1 | One-cycle reset pulse to the slot port |

## Verification
The bench builds the block with its defaults: a 12-bit address, eight vendor words and the slot base at 0x200. With these values the whole 4 KiB window can be addressed, including the unimplemented gap from 0x20 to 0x1FC and the last slot word at 0xFFC. The bench's slot responder answers after 0, 2 or 3 extra cycles. This makes the number of cycles `bus_ready` stays low observable, along with the address rebasing at both ends of the slot range.

// File: rtl/sdvf_pkg.sv
package sdvf_pkg;

    localparam int unsigned DATA_W      = 32;
    localparam logic [31:0] INFO_POR    = 32'h0001_0000;

    // Word indices of the vendor registers that have special rules
    localparam int unsigned IDX_INFO    = 0;
    localparam int unsigned IDX_PHY     = 4;
    localparam int unsigned IDX_EMMC    = 6;

    // Bit positions
    localparam int unsigned BIT_SWR     = 0;
    localparam int unsigned BIT_PHY_WR  = 24;
    localparam int unsigned BIT_PHY_RD  = 25;
    localparam int unsigned BIT_PHY_ACK = 26;
    localparam int unsigned BIT_TUNE    = 15;

    typedef enum logic [1:0] {
        RGN_VREG     = 2'd0,
        RGN_HOLE     = 2'd1,
        RGN_SLOT     = 2'd2,
        RGN_MISALIGN = 2'd3
    } region_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [DATA_W-1:0] data;
    } access_t;

    // Value that a vendor word holds after a write of d
    function automatic logic [DATA_W-1:0] shape_store(int unsigned idx,
                                                      logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r = d;
        if (idx == IDX_PHY)
            r[BIT_PHY_ACK] = d[BIT_PHY_WR] | d[BIT_PHY_RD];
        else if (idx == IDX_EMMC)
            r[BIT_TUNE] = 1'b0;
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] por_value(int unsigned idx);
        return (idx == IDX_INFO) ? INFO_POR : '0;
    endfunction

endpackage

// File: rtl/sdvf_decode.sv
module sdvf_decode
    import sdvf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned VREG_WORDS = 8,
    parameter int unsigned SLOT_BASE  = 'h200,
    localparam int unsigned IDX_W     = $clog2(VREG_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn,
    output logic [IDX_W-1:0]  widx,
    output logic [ADDR_W-1:0] slot_off
);
    localparam logic [ADDR_W-1:0] VREG_END = ADDR_W'(VREG_WORDS * 4);
    localparam logic [ADDR_W-1:0] SBASE    = ADDR_W'(SLOT_BASE);

    always_comb begin
        if (addr[1:0] != 2'b00)
            rgn = RGN_MISALIGN;
        else if (addr >= SBASE)
            rgn = RGN_SLOT;
        else if (addr < VREG_END)
            rgn = RGN_VREG;
        else
            rgn = RGN_HOLE;
    end

    assign widx     = addr[IDX_W+1:2];
    assign slot_off = addr - SBASE;

endmodule

// File: rtl/sdvf_vreg_file.sv
module sdvf_vreg_file
    import sdvf_pkg::*;
#(
    parameter int unsigned VREG_WORDS = 8,
    localparam int unsigned IDX_W     = $clog2(VREG_WORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              swr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word [VREG_WORDS];

    for (genvar i = 0; i < VREG_WORDS; i++) begin : g_word
        if (i == IDX_INFO) begin : g_ro
            // Information word: fixed contents, never written
            assign word[i] = por_value(i);
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || swr)
                    q <= por_value(i);
                else if (wr_en && wr_idx == IDX_W'(i))
                    q <= shape_store(i, wr_data);
            end
            assign word[i] = q;
        end
    end

    assign rd_data = word[rd_idx];

endmodule

// File: rtl/sdvf_fwd.sv
module sdvf_fwd
    import sdvf_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  access_t           acc,
    input  logic              sel,
    input  logic [ADDR_W-1:0] off,
    input  logic              swr,
    input  logic              slot_ack,
    input  logic [DATA_W-1:0] slot_rdata,
    output logic              slot_req,
    output logic              slot_we,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [DATA_W-1:0] slot_wdata,
    output logic              slot_rst,
    output logic              fwd_ready,
    output logic [DATA_W-1:0] fwd_rdata
);
    logic go;
    assign go         = acc.req && sel;
    assign slot_req   = go;
    assign slot_we    = go && acc.we;
    assign slot_addr  = off;
    assign slot_wdata = acc.data;
    assign fwd_ready  = go && slot_ack;
    assign fwd_rdata  = slot_rdata;

    always_ff @(posedge clk) begin
        if (rst)
            slot_rst <= 1'b0;
        else
            slot_rst <= swr;
    end

endmodule

// File: rtl/sdvf_frontend.sv
module sdvf_frontend
    import sdvf_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned VREG_WORDS = 8,
    parameter int unsigned SLOT_BASE  = 'h200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ready,
    output logic              bus_err,
    output logic [31:0]       bus_rdata,
    output logic              slot_req,
    output logic              slot_we,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [31:0]       slot_wdata,
    input  logic              slot_ack,
    input  logic [31:0]       slot_rdata,
    output logic              slot_rst
);
    localparam int unsigned IDX_W = $clog2(VREG_WORDS);

    region_e           rgn;
    logic [IDX_W-1:0]  widx;
    logic [ADDR_W-1:0] slot_off;
    access_t           acc;
    logic              vreg_wr, swr;
    logic [DATA_W-1:0] vreg_rd, fwd_rdata;
    logic              fwd_ready;

    assign acc = '{req: bus_req, we: bus_we, data: bus_wdata};

    sdvf_decode #(
        .ADDR_W(ADDR_W), .VREG_WORDS(VREG_WORDS), .SLOT_BASE(SLOT_BASE)
    ) dec_i (
        .addr(bus_addr), .rgn(rgn), .widx(widx), .slot_off(slot_off)
    );

    assign vreg_wr = acc.req && acc.we && rgn == RGN_VREG;
    assign swr     = vreg_wr && widx == IDX_W'(IDX_INFO) && acc.data[BIT_SWR];

    sdvf_vreg_file #(.VREG_WORDS(VREG_WORDS)) vf_i (
        .clk(clk), .rst(rst),
        .wr_en(vreg_wr), .wr_idx(widx), .wr_data(acc.data),
        .swr(swr), .rd_idx(widx), .rd_data(vreg_rd)
    );

    sdvf_fwd #(.ADDR_W(ADDR_W)) fwd_i (
        .clk(clk), .rst(rst), .acc(acc), .sel(rgn == RGN_SLOT),
        .off(slot_off), .swr(swr),
        .slot_ack(slot_ack), .slot_rdata(slot_rdata),
        .slot_req(slot_req), .slot_we(slot_we), .slot_addr(slot_addr),
        .slot_wdata(slot_wdata), .slot_rst(slot_rst),
        .fwd_ready(fwd_ready), .fwd_rdata(fwd_rdata)
    );

    always_comb begin
        bus_ready = 1'b0;
        bus_err   = 1'b0;
        bus_rdata = '0;
        if (acc.req) begin
            unique case (rgn)
                RGN_VREG: begin
                    bus_ready = 1'b1;
                    if (!acc.we) bus_rdata = vreg_rd;
                end
                RGN_HOLE:     bus_ready = 1'b1;
                RGN_SLOT: begin
                    bus_ready = fwd_ready;
                    bus_rdata = fwd_rdata;
                end
                RGN_MISALIGN: begin
                    bus_ready = 1'b1;
                    bus_err   = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/sdvf_checker.sv
module sdvf_checker
    import sdvf_pkg::*;
#(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned SLOT_BASE = 'h200
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ready,
    input logic              bus_err,
    input logic [31:0]       bus_rdata,
    input logic              slot_req,
    input logic              slot_ack,
    input logic              slot_rst
);
    localparam logic [ADDR_W-1:0] SBASE = ADDR_W'(SLOT_BASE);
    localparam logic [ADDR_W-1:0] A_EMMC = ADDR_W'(IDX_EMMC * 4);

    assert_info_reads_por_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr == '0) |-> bus_rdata == INFO_POR);

    assert_rst_pulse_after_swr_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_we && bus_addr == '0 && bus_wdata[BIT_SWR]) |=> slot_rst);

    assert_rst_pulse_single_R4: assert property (@(posedge clk) disable iff (rst)
        slot_rst |=> !slot_rst);

    assert_tune_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_we && bus_addr == A_EMMC) |-> !bus_rdata[BIT_TUNE]);

    assert_vendor_immediate_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr < SBASE) |-> bus_ready);

    assert_fwd_ready_follows_ack_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr >= SBASE && bus_addr[1:0] == 2'b00)
            |-> (slot_req && bus_ready == slot_ack));

    assert_no_stray_fwd_R10: assert property (@(posedge clk) disable iff (rst)
        slot_req |-> (bus_req && bus_addr >= SBASE && bus_addr[1:0] == 2'b00));

    assert_misalign_err_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_addr[1:0] != 2'b00) |-> (bus_ready && bus_err && bus_rdata == '0));

endmodule

bind sdvf_frontend sdvf_checker #(.ADDR_W(ADDR_W), .SLOT_BASE(SLOT_BASE)) chk_i (
    .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_err(bus_err), .bus_rdata(bus_rdata), .slot_req(slot_req),
    .slot_ack(slot_ack), .slot_rst(slot_rst)
);

// File: tb/sdvf_frontend_tb.sv
`timescale 1ns/1ps
module sdvf_frontend_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready, bus_err;
    logic [31:0] bus_rdata;
    logic        slot_req, slot_we, slot_rst;
    logic [11:0] slot_addr;
    logic [31:0] slot_wdata;
    logic        slot_ack = 1'b0;
    logic [31:0] slot_rdata = '0;

    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    sdvf_frontend dut_i (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_err(bus_err), .bus_rdata(bus_rdata), .slot_req(slot_req),
        .slot_we(slot_we), .slot_addr(slot_addr), .slot_wdata(slot_wdata),
        .slot_ack(slot_ack), .slot_rdata(slot_rdata), .slot_rst(slot_rst)
    );

    // Downstream slot responder: acts 1 ns after each rising edge
    int          slot_lat = 0, slot_cnt = 0, slot_seen = 0;
    logic [31:0] slot_resp = '0, cap_wdata = '0;
    logic [11:0] cap_addr = '0;
    logic        cap_we = 1'b0;

    always @(posedge clk) begin
        #1;
        if (slot_ack) begin
            slot_ack = 1'b0;
            slot_cnt = 0;
        end else if (slot_req) begin
            if (slot_cnt == 0) begin
                slot_seen++;
                cap_addr  = slot_addr;
                cap_we    = slot_we;
                cap_wdata = slot_wdata;
            end
            if (slot_cnt == slot_lat) begin
                slot_ack   = 1'b1;
                slot_rdata = slot_resp;
            end else begin
                slot_cnt++;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er, output int cyc);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        cyc = 0;
        #1;
        while (!bus_ready) begin
            @(negedge clk);
            cyc++;
            #1;
        end
        rd = bus_rdata;
        er = bus_err;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic er; int cyc;
        xfer(1'b1, a, d, rd, er, cyc);
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic er; int cyc;
        xfer(1'b0, a, '0, rd, er, cyc);
        chk(req, rd, exp);
    endtask

    task automatic t_reset_state();
        rd_chk("R1 info por", 12'h000, 32'h0001_0000);
        for (int i = 1; i < 8; i++) rd_chk("R1 vendor zero", 12'(i * 4), 32'h0);
        chk("R4 no pulse at reset", {31'b0, slot_rst}, 32'h0);
    endtask

    task automatic t_plain_words();
        wr(12'h004, 32'hDEAD_BEEF);
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h008, 32'h0000_8000);
        rd_chk("R7 word 0x04", 12'h004, 32'hDEAD_BEEF);
        rd_chk("R7 word 0x1C", 12'h01C, 32'hFFFF_FFFF);
        rd_chk("R7 word 0x08 bit15 kept", 12'h008, 32'h0000_8000);
    endtask

    task automatic t_info_readonly();
        wr(12'h000, 32'hFFFF_FFFE);
        chk("R2 no pulse without bit0", {31'b0, slot_rst}, 32'h0);
        rd_chk("R2 info unchanged", 12'h000, 32'h0001_0000);
        rd_chk("R2 other regs untouched", 12'h004, 32'hDEAD_BEEF);
    endtask

    task automatic t_phy_port();
        wr(12'h010, 32'h0100_00A5);
        rd_chk("R5 write req sets ack", 12'h010, 32'h0500_00A5);
        wr(12'h010, 32'h0200_0001);
        rd_chk("R5 read req sets ack", 12'h010, 32'h0600_0001);
        wr(12'h010, 32'h0400_1234);
        rd_chk("R5 ack cleared without req", 12'h010, 32'h0000_1234);
        wr(12'h010, 32'hFFFF_FFFF);
        rd_chk("R5 both req", 12'h010, 32'hFFFF_FFFF);
    endtask

    task automatic t_emmc_ctrl();
        wr(12'h018, 32'hFFFF_FFFF);
        rd_chk("R6 tune bit cleared", 12'h018, 32'hFFFF_7FFF);
        wr(12'h018, 32'h0000_8001);
        rd_chk("R6 tune bit only", 12'h018, 32'h0000_0001);
    endtask

    task automatic t_hole();
        wr(12'h020, 32'h1234_5678);
        wr(12'h1FC, 32'h8765_4321);
        rd_chk("R8 hole 0x20 reads 0", 12'h020, 32'h0);
        rd_chk("R8 hole 0x1FC reads 0", 12'h1FC, 32'h0);
        rd_chk("R8 hole write aliases nothing", 12'h000, 32'h0001_0000);
        rd_chk("R8 word 0x04 intact", 12'h004, 32'hDEAD_BEEF);
        chk("R8 hole not forwarded", slot_seen, 0);
    endtask

    task automatic t_soft_reset();
        wr(12'h014, 32'h0BAD_F00D);
        chk("R4 low before", {31'b0, slot_rst}, 32'h0);
        wr(12'h000, 32'h0000_0001);
        #1;
        chk("R4 pulse high one cycle after", {31'b0, slot_rst}, 32'h1);
        @(negedge clk); #1;
        chk("R4 pulse lasts one cycle", {31'b0, slot_rst}, 32'h0);
        rd_chk("R3 info after swr", 12'h000, 32'h0001_0000);
        rd_chk("R3 word 0x04 cleared", 12'h004, 32'h0);
        rd_chk("R3 word 0x10 cleared", 12'h010, 32'h0);
        rd_chk("R3 word 0x14 cleared", 12'h014, 32'h0);
        rd_chk("R3 word 0x18 cleared", 12'h018, 32'h0);
        rd_chk("R3 word 0x1C cleared", 12'h01C, 32'h0);
    endtask

    task automatic t_forward();
        logic [31:0] rd; logic er; int cyc; int seen0;
        seen0 = slot_seen;
        slot_lat = 2;
        xfer(1'b1, 12'h240, 32'hA5A5_0F0F, rd, er, cyc);
        chk("R9 write waits for ack", cyc, 3);
        chk("R9 write rebased addr", {20'b0, cap_addr}, 32'h040);
        chk("R9 write flag", {31'b0, cap_we}, 32'h1);
        chk("R9 write data", cap_wdata, 32'hA5A5_0F0F);
        slot_lat = 0; slot_resp = 32'hCAFE_0123;
        xfer(1'b0, 12'h200, '0, rd, er, cyc);
        chk("R9 read zero latency", cyc, 1);
        chk("R9 read data passthrough", rd, 32'hCAFE_0123);
        chk("R9 read base addr", {20'b0, cap_addr}, 32'h000);
        chk("R9 read flag", {31'b0, cap_we}, 32'h0);
        chk("R9 no err", {31'b0, er}, 32'h0);
        slot_lat = 3; slot_resp = 32'h1357_9BDF;
        xfer(1'b0, 12'hFFC, '0, rd, er, cyc);
        chk("R9 top addr latency", cyc, 4);
        chk("R9 top addr data", rd, 32'h1357_9BDF);
        chk("R9 top addr rebased", {20'b0, cap_addr}, 32'hDFC);
        chk("R9 one request each", slot_seen - seen0, 3);
    endtask

    task automatic t_misalign();
        logic [31:0] rd; logic er; int cyc; int seen0;
        seen0 = slot_seen;
        wr(12'h004, 32'h0000_00AA);
        xfer(1'b1, 12'h006, 32'hFFFF_FFFF, rd, er, cyc);
        chk("R10 err on misaligned write", {31'b0, er}, 32'h1);
        chk("R10 immediate", cyc, 0);
        rd_chk("R10 word 0x04 untouched", 12'h004, 32'h0000_00AA);
        xfer(1'b1, 12'h001, 32'h0000_0001, rd, er, cyc);
        #1;
        chk("R10 misaligned swr ignored", {31'b0, slot_rst}, 32'h0);
        rd_chk("R10 word 0x04 kept after bad swr", 12'h004, 32'h0000_00AA);
        xfer(1'b0, 12'h203, '0, rd, er, cyc);
        chk("R10 err in slot range", {31'b0, er}, 32'h1);
        chk("R10 read returns 0", rd, 32'h0);
        chk("R10 not forwarded", slot_seen - seen0, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        t_reset_state();
        t_plain_words();
        t_info_readonly();
        t_phy_port();
        t_emmc_ctrl();
        t_hole();
        t_soft_reset();
        t_forward();
        t_misalign();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule